// File: doc/BRIEF.md
# DMA Request Timeout Timer

This block watches one DMA channel for stalled peripheral traffic. While the channel is enabled and waiting for a peripheral request, it counts clock cycles through two stages. A coarse prescaler divides the clock by a selectable power of two. Its ticks then drive a period counter whose length is also a selectable power of two. If no request arrives before the period counter runs out, the block raises a sticky timeout flag. An interrupt line follows the flag whenever the interrupt enable is set.

Every request strobe restarts both stages, so the flag means the peripheral has been quiet for one full window. In wait mode the timer stays idle until the channel has seen its first request. Without wait mode it starts as soon as the channel is enabled. After a timeout both counters hold at zero. A new window starts only once software clears the flag.

The prescaler ratios are set by the parameters `PSC_LOG2_A`, `PSC_LOG2_B` and `PSC_LOG2_C`, which default to 8, 16 and 24, giving divide ratios of 256, 65536 and 16777216. The period lengths run from 4 to 512 ticks.

Top module: `dma_req_timeout`

## Requirements
- R1: While rst_ni is low, and after it is released with all inputs low, tmo_flag_o and irq_o are 0.
- R2: With psc_sel_i = 0 the timer is off: both counters are held at zero and tmo_flag_o never rises, however long the channel stays enabled.
- R3: While en_i is low both counters are held at zero. After en_i rises again, a full window must elapse before a timeout.
- R4: Period select code c (0 to 7) gives a window of 2^(c+2) prescaler ticks, which is 4, 8, 16, 32, 64, 128, 256 or 512.
- R5: Prescaler code 1, 2 or 3 makes one tick every 2^PSC_LOG2_A, 2^PSC_LOG2_B or 2^PSC_LOG2_C clock cycles. In non-wait mode, tmo_flag_o rises right after the N-th rising clock edge with en_i high, counting from the first such edge, where N is the prescaler ratio times the period length.
- R6: With wait_mode_i high, no time is counted until the first request has been sampled since en_i rose. The flag then rises N edges after the edge that sampled that request.
- R7: A request sampled at edge R resets both counters, so the flag rises no earlier than edge R+N.
- R8: tmo_flag_o stays 1 until flag_clr_i is sampled high, and no counting takes place while it is set. A clear at edge C drops the flag, and the next timeout comes at edge C+N.
- R9: irq_o is 1 exactly when tmo_flag_o is 1 and irq_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| psc_sel_i | input | 2 | Prescaler select: 0 turns the timer off, 1 to 3 pick a ratio |
| per_sel_i | input | 3 | Period select, a window of 2^(code+2) ticks |
| wait_mode_i | input | 1 | Hold off counting until the first request |
| req_i | input | 1 | Peripheral request strobe, one cycle per request |
| flag_clr_i | input | 1 | Clears the timeout flag |
| irq_en_i | input | 1 | Interrupt enable |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The flag is registered and is due one edge after the last counted edge. It therefore rises right after the N-th counted edge, where the first counted edge follows the enable, the request or the clear that opened the window. Each timeout check drives its stimulus at a falling edge. It then counts N-1 rising edges and confirms at the next falling edge that the flag is still low. After one more rising edge it confirms that the flag is high, so a window one cycle too short or too long fails. The interrupt follows the flag and its enable without a register, so it is checked at the same falling edge as the input change that should move it.

// File: rtl/dma_tmo_pkg.sv
package dma_tmo_pkg;

  typedef enum logic [1:0] {
    PSC_OFF   = 2'd0,
    PSC_DIV_A = 2'd1,
    PSC_DIV_B = 2'd2,
    PSC_DIV_C = 2'd3
  } psc_sel_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dma_tmo_prescale.sv
module dma_tmo_prescale #(
  parameter int unsigned PSC_LOG2_A = 8,
  parameter int unsigned PSC_LOG2_B = 16,
  parameter int unsigned PSC_LOG2_C = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  import dma_tmo_pkg::*;

  localparam int unsigned CNT_W = max3(PSC_LOG2_A, PSC_LOG2_B, PSC_LOG2_C);
  localparam int unsigned LOG2_TAB [4] = '{0, PSC_LOG2_A, PSC_LOG2_B, PSC_LOG2_C};

  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       term;

  assign term[0] = 1'b0;

  // one terminal decode per ratio: low bits all ones
  for (genvar k = 1; k < 4; k++) begin : g_term
    assign term[k] = &cnt_q[LOG2_TAB[k]-1:0];
  end

  assign tick_o = !clr_i && term[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dma_tmo_period.sv
module dma_tmo_period #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  localparam int unsigned N_SEL = 2 ** SEL_W;
  localparam int unsigned CNT_W = BASE_LOG2 + N_SEL - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [N_SEL-1:0] term;

  // window of 2^(BASE_LOG2+s) ticks ends when the low bits are all ones
  for (genvar s = 0; s < N_SEL; s++) begin : g_term
    assign term[s] = &cnt_q[BASE_LOG2+s-1:0];
  end

  assign expire_o = !clr_i && tick_i && term[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dma_tmo_ctrl.sv
module dma_tmo_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] psc_sel_i,
  input  logic       wait_mode_i,
  input  logic       req_i,
  input  logic       flag_clr_i,
  input  logic       expire_i,
  output logic       cnt_clr_o,
  output logic       flag_o,
  output logic       req_seen_o
);
  import dma_tmo_pkg::*;

  logic timer_on;
  logic armed;

  assign timer_on  = en_i && (psc_sel_e'(psc_sel_i) != PSC_OFF);
  assign armed     = !wait_mode_i || req_seen_o;
  // counters sit at zero unless a window is actually open
  assign cnt_clr_o = !timer_on || flag_o || req_i || !armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_seen_o <= 1'b0;
    else if (!en_i) req_seen_o <= 1'b0;
    else if (req_i) req_seen_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (expire_i)   flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/dma_req_timeout.sv
module dma_req_timeout #(
  parameter int unsigned PSC_LOG2_A = 8,
  parameter int unsigned PSC_LOG2_B = 16,
  parameter int unsigned PSC_LOG2_C = 24,
  parameter int unsigned PER_SEL_W  = 3,
  parameter int unsigned PER_BASE   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [1:0]           psc_sel_i,
  input  logic [PER_SEL_W-1:0] per_sel_i,
  input  logic                 wait_mode_i,
  input  logic                 req_i,
  input  logic                 flag_clr_i,
  input  logic                 irq_en_i,
  output logic                 tmo_flag_o,
  output logic                 irq_o
);

  logic cnt_clr;
  logic tick;
  logic expire;
  logic req_seen;

  dma_tmo_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .psc_sel_i   (psc_sel_i),
    .wait_mode_i (wait_mode_i),
    .req_i       (req_i),
    .flag_clr_i  (flag_clr_i),
    .expire_i    (expire),
    .cnt_clr_o   (cnt_clr),
    .flag_o      (tmo_flag_o),
    .req_seen_o  (req_seen)
  );

  dma_tmo_prescale #(
    .PSC_LOG2_A (PSC_LOG2_A),
    .PSC_LOG2_B (PSC_LOG2_B),
    .PSC_LOG2_C (PSC_LOG2_C)
  ) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .sel_i  (psc_sel_i),
    .tick_o (tick)
  );

  dma_tmo_period #(
    .SEL_W     (PER_SEL_W),
    .BASE_LOG2 (PER_BASE)
  ) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .tick_i   (tick),
    .sel_i    (per_sel_i),
    .expire_o (expire)
  );

  assign irq_o = tmo_flag_o && irq_en_i;

endmodule

// File: rtl/dma_req_timeout_chk.sv
module dma_req_timeout_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] psc_sel_i,
  input logic       wait_mode_i,
  input logic       req_i,
  input logic       flag_clr_i,
  input logic       tmo_flag_o,
  input logic       irq_o,
  input logic       req_seen
);

  assert_off_no_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag_o) |-> $past(psc_sel_i != 2'd0));

  assert_dis_no_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag_o) |-> $past(en_i));

  assert_wait_armed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag_o) |-> $past(!wait_mode_i || req_seen));

  assert_req_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag_o) |-> $past(!req_i));

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_flag_o && !flag_clr_i |=> tmo_flag_o);

  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_flag_o && flag_clr_i |=> !tmo_flag_o);

  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tmo_flag_o);

endmodule

bind dma_req_timeout dma_req_timeout_chk u_chk (.*);

// File: tb/dma_req_timeout_test.sv
module dma_req_timeout_test;

  localparam int unsigned LA = 2;
  localparam int unsigned LB = 3;
  localparam int unsigned LC = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] psc_sel_i = 2'd0;
  logic [2:0] per_sel_i = 3'd0;
  logic       wait_mode_i = 1'b0;
  logic       req_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       tmo_flag_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_req_timeout #(
    .PSC_LOG2_A (LA),
    .PSC_LOG2_B (LB),
    .PSC_LOG2_C (LC)
  ) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .psc_sel_i   (psc_sel_i),
    .per_sel_i   (per_sel_i),
    .wait_mode_i (wait_mode_i),
    .req_i       (req_i),
    .flag_clr_i  (flag_clr_i),
    .irq_en_i    (irq_en_i),
    .tmo_flag_o  (tmo_flag_o),
    .irq_o       (irq_o)
  );

  function automatic int win(int psc, int per);
    int l;
    l = (psc == 1) ? LA : (psc == 2) ? LB : LC;
    return (1 << l) * (1 << (per + 2));
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // window opens at the next rising edge; flag due right after the n-th edge
  task automatic expect_timeout(input int n, input string tag);
    if (n > 1) edges(n - 1);
    check(tmo_flag_o, 1'b0, {tag, " early"});
    edges(1);
    check(tmo_flag_o, 1'b1, {tag, " due"});
  endtask

  task automatic pulse_req();
    req_i = 1'b1;
    edges(1);
    req_i = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr_i = 1'b1;
    edges(1);
    flag_clr_i = 1'b0;
  endtask

  task automatic do_reset();
    en_i = 1'b0; psc_sel_i = 2'd0; per_sel_i = 3'd0; wait_mode_i = 1'b0;
    req_i = 1'b0; flag_clr_i = 1'b0; irq_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    edges(2);
    rst_ni = 1'b1;
    edges(1);
  endtask

  task automatic t_reset_r1();
    do_reset();
    check(tmo_flag_o, 1'b0, "R1 flag after reset");
    check(irq_o, 1'b0, "R1 irq after reset");
    psc_sel_i = 2'd1; en_i = 1'b1; irq_en_i = 1'b1;
    expect_timeout(win(1, 0), "R1 setup");
    rst_ni = 1'b0;
    #2;
    check(tmo_flag_o, 1'b0, "R1 flag async reset");
    check(irq_o, 1'b0, "R1 irq async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_periods_r4();
    for (int c = 0; c < 8; c++) begin
      do_reset();
      psc_sel_i = 2'd1; per_sel_i = 3'(c);
      en_i = 1'b1;
      expect_timeout(win(1, c), $sformatf("R4 period code %0d", c));
    end
  endtask

  task automatic t_prescale_r5();
    do_reset();
    psc_sel_i = 2'd2; per_sel_i = 3'd3; en_i = 1'b1;
    expect_timeout(win(2, 3), "R5 psc code 2");
    do_reset();
    psc_sel_i = 2'd3; per_sel_i = 3'd0; en_i = 1'b1;
    expect_timeout(win(3, 0), "R5 psc code 3 short");
    do_reset();
    psc_sel_i = 2'd3; per_sel_i = 3'd7; en_i = 1'b1;
    expect_timeout(win(3, 7), "R5 psc code 3 long");
    do_reset();
    psc_sel_i = 2'd1; per_sel_i = 3'd2; en_i = 1'b1;
    expect_timeout(win(1, 2), "R5 psc code 1");
  endtask

  task automatic t_off_r2();
    do_reset();
    psc_sel_i = 2'd0; per_sel_i = 3'd0; en_i = 1'b1;
    edges(4 * win(3, 0));
    check(tmo_flag_o, 1'b0, "R2 psc off no timeout");
    psc_sel_i = 2'd1;
    expect_timeout(win(1, 0), "R2 full window after psc on");
  endtask

  task automatic t_disable_r3();
    do_reset();
    psc_sel_i = 2'd1; per_sel_i = 3'd1; en_i = 1'b1;
    edges(win(1, 1) - 2);
    en_i = 1'b0;
    edges(3 * win(1, 1));
    check(tmo_flag_o, 1'b0, "R3 disabled no timeout");
    en_i = 1'b1;
    expect_timeout(win(1, 1), "R3 full window after re-enable");
  endtask

  task automatic t_wait_r6();
    do_reset();
    psc_sel_i = 2'd1; per_sel_i = 3'd0; wait_mode_i = 1'b1; en_i = 1'b1;
    edges(3 * win(1, 0));
    check(tmo_flag_o, 1'b0, "R6 no count before first request");
    pulse_req();
    expect_timeout(win(1, 0), "R6 window after first request");
    // re-arm requirement after enable drop
    pulse_clr();
    en_i = 1'b0;
    edges(2);
    en_i = 1'b1;
    edges(3 * win(1, 0));
    check(tmo_flag_o, 1'b0, "R6 re-armed after enable drop");
  endtask

  task automatic t_req_r7();
    do_reset();
    psc_sel_i = 2'd2; per_sel_i = 3'd1; en_i = 1'b1;
    edges(win(2, 1) - 2);
    pulse_req();
    expect_timeout(win(2, 1), "R7 restart on request");
    do_reset();
    psc_sel_i = 2'd1; per_sel_i = 3'd0; en_i = 1'b1;
    edges(3);
    pulse_req();
    edges(5);
    pulse_req();
    expect_timeout(win(1, 0), "R7 second request restarts");
  endtask

  task automatic t_flag_r8();
    do_reset();
    psc_sel_i = 2'd1; per_sel_i = 3'd0; en_i = 1'b1;
    expect_timeout(win(1, 0), "R8 setup");
    edges(3 * win(1, 0));
    check(tmo_flag_o, 1'b1, "R8 flag sticky");
    pulse_clr();
    expect_timeout(win(1, 0), "R8 full window after clear");
    en_i = 1'b0;
    edges(4);
    check(tmo_flag_o, 1'b1, "R8 sticky across disable");
  endtask

  task automatic t_irq_r9();
    do_reset();
    irq_en_i = 1'b1;
    check(irq_o, 1'b0, "R9 irq low without flag");
    psc_sel_i = 2'd1; per_sel_i = 3'd0; en_i = 1'b1;
    expect_timeout(win(1, 0), "R9 setup");
    check(irq_o, 1'b1, "R9 irq with flag and enable");
    irq_en_i = 1'b0;
    #1;
    check(irq_o, 1'b0, "R9 irq masked");
    irq_en_i = 1'b1;
    pulse_clr();
    check(irq_o, 1'b0, "R9 irq drops with flag");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_periods_r4();
    t_prescale_r5();
    t_off_r2();
    t_disable_r3();
    t_wait_r6();
    t_req_r7();
    t_flag_r8();
    t_irq_r9();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule